// File: doc/BRIEF.md
# SDRAM Refresh Command Sequencer

This block sits beside the access scheduler of an SDRAM controller and owns the refresh side of the command bus. It takes a periodic auto-refresh request, a request to put the memory into self refresh, and a request to bring it back out. It also takes a status input that says whether every bank is already closed. From these it drives the row strobe, column strobe, write enable and clock enable pins. Whenever the scheduler must keep off the bus, it raises a busy flag.

A refresh of either kind is only started when all banks report precharged. A request that arrives while a bank is still open waits inside the block until the banks close. After every auto refresh, and after leaving self refresh, a row-cycle gap of `TRC` clock cycles is enforced. This gap holds off the next refresh and any access. Outside of the refresh commands the pins carry a no-operation pattern. An exit request that arrives while the memory is awake is reported on an error output.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the pins show {cke,ras_n,cas_n,we_n} = 4'b1111, busy is 0 and exit_err is 0.
- R2: An auto-refresh request sampled at a clock edge, with banks idle and no gap pending, puts 4'b1001 ({cke,ras_n,cas_n,we_n}) on the pins for exactly one cycle, starting right after that edge.
- R3: A refresh of either kind is never issued while banks_idle is low. Such a request is held and issued in the cycle after the first edge at which banks_idle is high.
- R4: If a refresh command shows in output cycle k, no other refresh command shows before cycle k+TRC. A request held back by this gap shows at exactly k+TRC. A request that arrives later shows in the cycle after it is sampled.
- R5: busy is high in the cycles of a refresh command and the TRC-1 cycles after it, while a request is held, and throughout self refresh. Otherwise it is low.
- R6: A self-refresh entry shows 4'b0001 for one cycle. After that the pins hold 4'b0111 (clock enable low, command lines at no-operation) until exit.
- R7: An exit request sampled during self refresh returns the pins to 4'b1111 in the next cycle. busy stays high in that cycle and for TRC-1 cycles after it.
- R8: Auto-refresh and self-refresh-entry requests sampled during self refresh, including at the exit edge, are discarded and never issued.
- R9: An exit request sampled while awake raises exit_err for exactly the next cycle and leaves the pins and busy unchanged.
- R10: Auto-refresh and self-refresh-entry requests sampled at the same edge issue the auto refresh first and the self-refresh entry TRC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_req | input | 1 | Auto-refresh request pulse |
| sr_enter_req | input | 1 | Self-refresh entry request pulse |
| sr_exit_req | input | 1 | Self-refresh exit request pulse |
| banks_idle | input | 1 | High when every bank is precharged |
| cke | output | 1 | Clock enable pin |
| ras_n | output | 1 | Row strobe pin, active low |
| cas_n | output | 1 | Column strobe pin, active low |
| we_n | output | 1 | Write enable pin, active low |
| busy | output | 1 | Scheduler must not issue commands |
| exit_err | output | 1 | One-cycle flag for an exit request while awake |

## Verification
The bench sweeps the arrival offset of a second auto refresh across the whole gap window and past it. A timer that is off by one would show the second command a cycle early or late. A design that dropped held requests would never show it at all. Requests are also stalled behind a closed-bank condition for several lengths. A design that ignores banks_idle would refresh an open bank, and one that forgets the held request would stay silent once the banks close. Self refresh is checked for requests made while asleep, which must not fire after exit, and for an entry made right after exit, which must wait out the full gap. It is also checked for simultaneous requests, where the wrong priority swaps the command order.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;

    typedef struct packed {
        logic cke;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam pin_cmd_t CMD_NOP       = 4'b1111;
    localparam pin_cmd_t CMD_AUTO      = 4'b1001;
    localparam pin_cmd_t CMD_SLEEP_IN  = 4'b0001;
    localparam pin_cmd_t CMD_SLEEP_NOP = 4'b0111;

    typedef enum logic {
        PH_AWAKE,
        PH_ASLEEP
    } phase_t;

    function automatic logic is_refresh(input pin_cmd_t c);
        return !c.ras_n && !c.cas_n && c.we_n;
    endfunction

endpackage

// File: rtl/rfsh_req_hold.sv
module rfsh_req_hold (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic take,
    input  logic drop,
    output logic want,
    output logic held
);

    logic held_q;

    assign want = (held_q | req) & ~drop;
    assign held = held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= 1'b0;
        else if (take || drop)
            held_q <= 1'b0;
        else
            held_q <= held_q | req;
    end

    // R3
    take_needs_want_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> want);

endmodule

// File: rtl/rfsh_gap_timer.sv
module rfsh_gap_timer #(
    parameter int TRC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic ready,
    output logic active
);

    localparam int CW = $clog2(TRC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(TRC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign ready  = (cnt_q <= CW'(1));
    assign active = (cnt_q != '0);

    // R4
    gap_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && active) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R4
    gap_load_ok_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == CW'(TRC)));

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import sdram_rfsh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     want_ar,
    input  logic     want_sr,
    input  logic     exit_req,
    input  logic     banks_idle,
    input  logic     gap_ready,
    output pin_cmd_t cmd,
    output logic     asleep,
    output logic     take_ar,
    output logic     take_sr,
    output logic     load_gap,
    output logic     exit_err
);

    phase_t   phase_q, phase_d;
    pin_cmd_t cmd_q, cmd_d;
    logic     err_q;
    logic     go, wake;

    always_comb begin
        go       = (phase_q == PH_AWAKE) && banks_idle && gap_ready;
        take_ar  = go && want_ar;
        take_sr  = go && want_sr && !want_ar;
        wake     = (phase_q == PH_ASLEEP) && exit_req;
        load_gap = take_ar || wake;

        phase_d = phase_q;
        if (take_sr)
            phase_d = PH_ASLEEP;
        else if (wake)
            phase_d = PH_AWAKE;

        if (take_ar)
            cmd_d = CMD_AUTO;
        else if (take_sr)
            cmd_d = CMD_SLEEP_IN;
        else if (phase_d == PH_ASLEEP)
            cmd_d = CMD_SLEEP_NOP;
        else
            cmd_d = CMD_NOP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_AWAKE;
            cmd_q   <= CMD_NOP;
            err_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cmd_q   <= cmd_d;
            err_q   <= exit_req && (phase_q == PH_AWAKE);
        end
    end

    assign cmd      = cmd_q;
    assign asleep   = (phase_q == PH_ASLEEP);
    assign exit_err = err_q;

    // R3
    refresh_idle_chk: assert property (@(posedge clk) disable iff (rst)
        is_refresh(cmd_q) |-> $past(banks_idle));

    // R4
    refresh_gap_chk: assert property (@(posedge clk) disable iff (rst)
        is_refresh(cmd_q) |-> $past(gap_ready));

    // R6
    sleep_cke_low_chk: assert property (@(posedge clk) disable iff (rst)
        asleep |-> !cmd_q.cke);

    // R7
    wake_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_q.cke) |-> ($past(asleep) && $past(exit_req)));

endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl
    import sdram_rfsh_pkg::*;
#(
    parameter int TRC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic ar_req,
    input  logic sr_enter_req,
    input  logic sr_exit_req,
    input  logic banks_idle,
    output logic cke,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic busy,
    output logic exit_err
);

    pin_cmd_t cmd;
    logic want_ar, want_sr, held_ar, held_sr;
    logic take_ar, take_sr, load_gap;
    logic gap_ready, gap_active, asleep;

    rfsh_req_hold u_ar_hold (
        .clk(clk), .rst(rst), .req(ar_req), .take(take_ar),
        .drop(asleep), .want(want_ar), .held(held_ar)
    );

    rfsh_req_hold u_sr_hold (
        .clk(clk), .rst(rst), .req(sr_enter_req), .take(take_sr),
        .drop(asleep), .want(want_sr), .held(held_sr)
    );

    rfsh_gap_timer #(.TRC(TRC)) u_gap (
        .clk(clk), .rst(rst), .load(load_gap),
        .ready(gap_ready), .active(gap_active)
    );

    rfsh_seq u_seq (
        .clk(clk), .rst(rst), .want_ar(want_ar), .want_sr(want_sr),
        .exit_req(sr_exit_req), .banks_idle(banks_idle), .gap_ready(gap_ready),
        .cmd(cmd), .asleep(asleep), .take_ar(take_ar), .take_sr(take_sr),
        .load_gap(load_gap), .exit_err(exit_err)
    );

    assign cke   = cmd.cke;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign busy  = held_ar | held_sr | gap_active | asleep;

    // R5
    cke_low_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> busy);

    // R5
    refresh_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && !cas_n) |-> busy);

endmodule

// File: tb/sdram_refresh_ctrl_test.sv
`timescale 1ns/1ps
module sdram_refresh_ctrl_test;

    localparam int TRC = 6;
    localparam logic [3:0] P_NOP = 4'b1111, P_AR = 4'b1001,
                           P_SRI = 4'b0001, P_SLP = 4'b0111;

    logic clk = 1'b0;
    logic rst, ar_req, sr_enter_req, sr_exit_req, banks_idle;
    logic cke, ras_n, cas_n, we_n, busy, exit_err;
    int vecs = 0, errs = 0;

    always #10 clk = ~clk;

    sdram_refresh_ctrl #(.TRC(TRC)) uut (
        .clk(clk), .rst(rst), .ar_req(ar_req), .sr_enter_req(sr_enter_req),
        .sr_exit_req(sr_exit_req), .banks_idle(banks_idle),
        .cke(cke), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .busy(busy), .exit_err(exit_err)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [3:0] pins,
                       input logic b, input logic e);
        logic [5:0] act, exp;
        act = {exit_err, busy, cke, ras_n, cas_n, we_n};
        exp = {e, b, pins};
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got err,busy,pins=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drain();
        while (busy) step();
    endtask

    initial begin
        rst = 1'b1; ar_req = 0; sr_enter_req = 0; sr_exit_req = 0; banks_idle = 1;
        step();
        chk("R1 in reset", P_NOP, 0, 0);
        step();
        rst = 1'b0;
        step();
        chk("R1 after reset", P_NOP, 0, 0);

        // R2 / R4 / R5: second auto refresh at every offset across the gap
        for (int o = 0; o <= TRC + 1; o++) begin
            int ex;
            ar_req = 1; step(); ar_req = 0;
            chk("R2 first auto refresh", P_AR, 1, 0);
            ex = (o + 1 > TRC) ? o + 1 : TRC;
            for (int p = 1; p <= ex; p++) begin
                ar_req = (p - 1 == o); step(); ar_req = 0;
                if (p == ex) chk("R4 spaced auto refresh", P_AR, 1, 0);
                else         chk("R5 gap window", P_NOP, (p < TRC), 0);
            end
            repeat (TRC) step();
            chk("R5 busy released", P_NOP, 0, 0);
        end

        // R3: held while a bank is open
        for (int d = 1; d <= 4; d++) begin
            banks_idle = 0;
            ar_req = 1; step(); ar_req = 0;
            chk("R3 held, no command", P_NOP, 1, 0);
            for (int k = 1; k < d; k++) begin
                step(); chk("R3 still held", P_NOP, 1, 0);
            end
            banks_idle = 1; step();
            chk("R3 issued once idle", P_AR, 1, 0);
            drain();
        end

        // R3 / R6 / R8 / R7: self refresh
        banks_idle = 0;
        sr_enter_req = 1; step(); sr_enter_req = 0;
        chk("R3 entry held", P_NOP, 1, 0);
        banks_idle = 1; step();
        chk("R6 entry command", P_SRI, 1, 0);
        for (int k = 1; k <= 4; k++) begin
            ar_req = (k == 2); sr_enter_req = (k == 3); step();
            ar_req = 0; sr_enter_req = 0;
            chk("R6 sleeping pins", P_SLP, 1, 0);
        end
        sr_exit_req = 1; ar_req = 1; step(); sr_exit_req = 0; ar_req = 0;
        chk("R7 exit cke high", P_NOP, 1, 0);
        for (int p = 1; p <= TRC + 2; p++) begin
            step(); chk("R8 no stray refresh after exit", P_NOP, (p < TRC), 0);
        end

        // R7: entry right after exit waits the full gap
        sr_enter_req = 1; step(); sr_enter_req = 0;
        chk("R6 entry again", P_SRI, 1, 0);
        sr_exit_req = 1; step(); sr_exit_req = 0;
        chk("R7 exit", P_NOP, 1, 0);
        for (int p = 1; p <= TRC; p++) begin
            sr_enter_req = (p == 1); step(); sr_enter_req = 0;
            if (p == TRC) chk("R7 entry after exit gap", P_SRI, 1, 0);
            else          chk("R7 exit gap busy", P_NOP, 1, 0);
        end
        sr_exit_req = 1; step(); sr_exit_req = 0;
        drain();

        // R9: exit while awake
        sr_exit_req = 1; step(); sr_exit_req = 0;
        chk("R9 error flag", P_NOP, 0, 1);
        step();
        chk("R9 error clears", P_NOP, 0, 0);

        // R10: simultaneous requests
        ar_req = 1; sr_enter_req = 1; step(); ar_req = 0; sr_enter_req = 0;
        chk("R10 auto refresh first", P_AR, 1, 0);
        for (int p = 1; p <= TRC; p++) begin
            step();
            if (p == TRC) chk("R10 entry second", P_SRI, 1, 0);
            else          chk("R10 waiting", P_NOP, 1, 0);
        end
        sr_exit_req = 1; step(); sr_exit_req = 0;
        drain();
        chk("R5 final idle", P_NOP, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule